// File: doc/BRIEF.md
# Virtual Address Translation Front End with Fault Syndrome Encoding

This block stands between the load, store and fetch path of a processor and its memory. Each cycle it can accept one request. A request carries a virtual address, an access kind and the current virtual-mode status bit. In the same cycle it also receives the result of a translation table lookup, which is produced outside the block. When translation is active and the lookup hits, the block returns the physical page address and the permissions that the lookup supplied. When translation is disabled, or no memory management unit is configured present, the block passes the page-aligned virtual address through unchanged with all permissions granted.

When a translated request misses or violates protection, the block records the faulting address and a syndrome word in two registers and pulses a fault request for one cycle. The fault then stays pending until the exception logic acknowledges it. If a second translation fault arrives while the first is still pending and unacknowledged, the block does not overwrite the recorded state. Instead it raises a sticky fatal flag, which only reset clears.

Top module: `mmu_xlate_front`

## Requirements
- R1: After reset, paValid, faultReq, faultPending and recursiveFault are 0, and earOut and esrOut are 0.
- R2: When msrVm is 0, a request yields paValid=1 on the next cycle, with paPage equal to reqVaddr with its low log2(PAGE_BYTES) bits cleared and paProt all ones. The lookup inputs have no effect, and no fault is raised.
- R3: The unit counts as present only when cfgMmuPresent is 1 and either cfgFullVersion is 0 or verMmuField is 1. When it is not present, requests bypass translation as in R2 even with msrVm=1.
- R4: With translation active and lkHit=1, the next cycle shows paValid=1, paPage = lkPbase + (page-aligned reqVaddr) − lkVbase, and paProt = lkProt.
- R5: With translation active and lkHit=0, the next cycle shows faultReq=1 for exactly one cycle, earOut equal to the full reqVaddr, and paValid=0.
- R6: The syndrome's bits [4:0] hold 16 for a protection fault (lkErrProt=1) on a load or store, 17 for a protection fault on a fetch, 18 for a miss (lkErrProt=0) on a load or store, and 19 for a miss on a fetch. The access kind is encoded as 0 = load, 1 = store, 2 = fetch.
- R7: Syndrome bit 10 is 1 exactly when the faulting access is a store (kind 1). All other syndrome bits are 0.
- R8: A recorded fault sets faultPending. faultPending stays set until a cycle with faultAck=1 and no new fault, after which it is 0.
- R9: A translation fault that arrives while faultPending=1 and faultAck=0 sets recursiveFault. recursiveFault stays set until reset. In that case there is no faultReq pulse, and earOut and esrOut keep their earlier values.
- R10: A translation fault in the same cycle as faultAck=1 is treated as a fresh fault. It produces a faultReq pulse and new earOut/esrOut values, faultPending stays 1, and recursiveFault does not change.
- R11: paValid is 1 only in the cycle after an accepted bypass or hit request. It is 0 in cycles that follow no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Access request this cycle |
| reqVaddr | input | ADDR_W | Virtual address of the access |
| reqKind | input | 2 | 0 load, 1 store, 2 fetch |
| msrVm | input | 1 | Virtual-mode status bit |
| cfgMmuPresent | input | 1 | Configuration: unit built in |
| cfgFullVersion | input | 1 | Configuration: full version register in use |
| verMmuField | input | 1 | Unit-use field of the version register |
| lkHit | input | 1 | Lookup hit |
| lkErrProt | input | 1 | Lookup error kind: 1 protection, 0 miss |
| lkVbase | input | ADDR_W | Matched virtual page base |
| lkPbase | input | ADDR_W | Matched physical page base |
| lkProt | input | PROT_W | Matched permissions |
| faultAck | input | 1 | Exception logic has taken the pending fault |
| paValid | output | 1 | paPage/paProt valid |
| paPage | output | ADDR_W | Physical page address |
| paProt | output | PROT_W | Permissions of the page |
| faultReq | output | 1 | One-cycle fault request |
| earOut | output | ADDR_W | Exception address register |
| esrOut | output | ESR_W | Exception syndrome register |
| faultPending | output | 1 | A fault awaits acknowledge |
| recursiveFault | output | 1 | Sticky fatal recursive-fault flag |

## Verification
An acknowledge and a new translation fault can land in the same cycle. In that case the clearing of the pending state and the detection of a recursive fault compete with each other. The bench records one miss, then issues a second fault with faultAck held high in that same cycle. It expects a fresh pulse, an updated address and syndrome, pending still set, and no fatal flag. A companion scenario repeats the second fault without the acknowledge. There it expects the recorded state to be frozen and the sticky flag to rise.

// File: rtl/mmu_xlate_pkg.sv
package mmu_xlate_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } accKindE;

  typedef struct packed {
    logic loadPa;
    logic useBypass;
    logic loadFault;
  } xlStrobeT;

  localparam int CODE_PROT = 16;
  localparam int CODE_MISS = 18;
  localparam int STORE_BIT = 10;
endpackage

// File: rtl/mmu_xlate_ctrl.sv
module mmu_xlate_ctrl
  import mmu_xlate_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     msrVm,
  input  logic     cfgMmuPresent,
  input  logic     cfgFullVersion,
  input  logic     verMmuField,
  input  logic     lkHit,
  input  logic     faultAck,
  output xlStrobeT strobe,
  output logic     paValid,
  output logic     faultReq,
  output logic     faultPending,
  output logic     recursiveFault
);
  logic mmuOn, translate, bypassReq, hitReq, faultEvt, recursiveEvt, freshFault;
  logic paValidQ, faultReqQ, pendingQ, recursiveQ;

  always_comb begin
    mmuOn        = cfgMmuPresent && (!cfgFullVersion || verMmuField);
    translate    = mmuOn && msrVm;
    bypassReq    = reqValid && !translate;
    hitReq       = reqValid && translate && lkHit;
    faultEvt     = reqValid && translate && !lkHit;
    recursiveEvt = faultEvt && pendingQ && !faultAck;
    freshFault   = faultEvt && !recursiveEvt;
    strobe.loadPa    = bypassReq || hitReq;
    strobe.useBypass = !translate;
    strobe.loadFault = freshFault;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      paValidQ   <= 1'b0;
      faultReqQ  <= 1'b0;
      pendingQ   <= 1'b0;
      recursiveQ <= 1'b0;
    end else begin
      paValidQ   <= strobe.loadPa;
      faultReqQ  <= freshFault;
      if (freshFault)    pendingQ <= 1'b1;
      else if (faultAck) pendingQ <= 1'b0;
      recursiveQ <= recursiveQ || recursiveEvt;
    end
  end

  assign paValid        = paValidQ;
  assign faultReq       = faultReqQ;
  assign faultPending   = pendingQ;
  assign recursiveFault = recursiveQ;

  // R5
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultReq |-> !paValid);
  // R8
  fault_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultReq |-> faultPending);
  // R9
  recursive_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    recursiveFault |=> recursiveFault);
  // R11
  pa_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !paValid);
endmodule

// File: rtl/mmu_xlate_dp.sv
module mmu_xlate_dp
  import mmu_xlate_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int PROT_W     = 3,
  parameter int ESR_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlStrobeT          strobe,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic [1:0]        reqKind,
  input  logic              lkErrProt,
  input  logic [ADDR_W-1:0] lkVbase,
  input  logic [ADDR_W-1:0] lkPbase,
  input  logic [PROT_W-1:0] lkProt,
  output logic [ADDR_W-1:0] paPage,
  output logic [PROT_W-1:0] paProt,
  output logic [ADDR_W-1:0] earOut,
  output logic [ESR_W-1:0]  esrOut
);
  localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ~((ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1));

  logic [ADDR_W-1:0] vPage, paPageD;
  logic [PROT_W-1:0] protD;
  logic [ESR_W-1:0]  esrD;
  logic [4:0]        codeD;
  logic [ADDR_W-1:0] paPageQ, earQ;
  logic [PROT_W-1:0] protQ;
  logic [ESR_W-1:0]  esrQ;

  always_comb begin
    vPage   = reqVaddr & PAGE_MASK;
    paPageD = strobe.useBypass ? vPage : (lkPbase + vPage - lkVbase);
    protD   = strobe.useBypass ? {PROT_W{1'b1}} : lkProt;
    codeD   = lkErrProt ? 5'(CODE_PROT) : 5'(CODE_MISS);
    if (reqKind == ACC_FETCH) codeD = codeD + 5'd1;
    esrD            = '0;
    esrD[4:0]       = codeD;
    esrD[STORE_BIT] = (reqKind == ACC_STORE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      paPageQ <= '0;
      protQ   <= '0;
      earQ    <= '0;
      esrQ    <= '0;
    end else begin
      if (strobe.loadPa) begin
        paPageQ <= paPageD;
        protQ   <= protD;
      end
      if (strobe.loadFault) begin
        earQ <= reqVaddr;
        esrQ <= esrD;
      end
    end
  end

  assign paPage = paPageQ;
  assign paProt = protQ;
  assign earOut = earQ;
  assign esrOut = esrQ;

  // R2
  bypass_prot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadPa && strobe.useBypass) |=> (paProt == {PROT_W{1'b1}}));
  // R6
  syndrome_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadFault |=> (esrOut[4:2] == 3'b100));
  // R5
  ear_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadFault |=> (earOut == $past(reqVaddr)));
endmodule

// File: rtl/mmu_xlate_front.sv
module mmu_xlate_front
  import mmu_xlate_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int PROT_W     = 3,
  parameter int ESR_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic [1:0]        reqKind,
  input  logic              msrVm,
  input  logic              cfgMmuPresent,
  input  logic              cfgFullVersion,
  input  logic              verMmuField,
  input  logic              lkHit,
  input  logic              lkErrProt,
  input  logic [ADDR_W-1:0] lkVbase,
  input  logic [ADDR_W-1:0] lkPbase,
  input  logic [PROT_W-1:0] lkProt,
  input  logic              faultAck,
  output logic              paValid,
  output logic [ADDR_W-1:0] paPage,
  output logic [PROT_W-1:0] paProt,
  output logic              faultReq,
  output logic [ADDR_W-1:0] earOut,
  output logic [ESR_W-1:0]  esrOut,
  output logic              faultPending,
  output logic              recursiveFault
);
  xlStrobeT strobe;

  mmu_xlate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .msrVm(msrVm),
    .cfgMmuPresent(cfgMmuPresent), .cfgFullVersion(cfgFullVersion),
    .verMmuField(verMmuField), .lkHit(lkHit), .faultAck(faultAck),
    .strobe(strobe), .paValid(paValid), .faultReq(faultReq),
    .faultPending(faultPending), .recursiveFault(recursiveFault)
  );

  mmu_xlate_dp #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .PROT_W(PROT_W), .ESR_W(ESR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqVaddr(reqVaddr),
    .reqKind(reqKind), .lkErrProt(lkErrProt), .lkVbase(lkVbase),
    .lkPbase(lkPbase), .lkProt(lkProt), .paPage(paPage), .paProt(paProt),
    .earOut(earOut), .esrOut(esrOut)
  );
endmodule

// File: tb/mmu_xlate_front_bench.sv
`timescale 1ns/1ps
module mmu_xlate_front_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic [1:0]  reqKind = '0;
  logic        msrVm = 1'b0;
  logic        cfgMmuPresent = 1'b1;
  logic        cfgFullVersion = 1'b0;
  logic        verMmuField = 1'b0;
  logic        lkHit = 1'b0;
  logic        lkErrProt = 1'b0;
  logic [31:0] lkVbase = '0;
  logic [31:0] lkPbase = '0;
  logic [2:0]  lkProt = '0;
  logic        faultAck = 1'b0;
  logic        paValid, faultReq, faultPending, recursiveFault;
  logic [31:0] paPage, earOut, esrOut;
  logic [2:0]  paProt;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mmu_xlate_front u_mmu_xlate_front (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expPage(input logic [31:0] v);
    return v & 32'hFFFF_F000;
  endfunction

  function automatic logic [31:0] expEsr(input logic [1:0] k, input logic prot);
    logic [31:0] e;
    e = prot ? 32'd16 : 32'd18;
    if (k == 2'd2) e = e + 32'd1;
    if (k == 2'd1) e = e | 32'h400;
    return e;
  endfunction

  task automatic doReq(input logic [31:0] va, input logic [1:0] k, input logic vm,
                       input logic hit, input logic errProt, input logic ack);
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; reqKind = k; msrVm = vm;
    lkHit = hit; lkErrProt = errProt; faultAck = ack;
    @(negedge clk);
    reqValid = 1'b0; faultAck = 1'b0; lkHit = 1'b0;
  endtask

  task automatic ackOnly();
    @(negedge clk); faultAck = 1'b1;
    @(negedge clk); faultAck = 1'b0;
  endtask

  task automatic applyReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic tReset();
    chk("R1 paValid", {31'b0, paValid}, 32'd0);
    chk("R1 faultReq", {31'b0, faultReq}, 32'd0);
    chk("R1 pending", {31'b0, faultPending}, 32'd0);
    chk("R1 recursive", {31'b0, recursiveFault}, 32'd0);
    chk("R1 ear", earOut, 32'd0);
    chk("R1 esr", esrOut, 32'd0);
  endtask

  task automatic tBypass();
    lkVbase = 32'h0000_1000; lkPbase = 32'h7000_0000; lkProt = 3'b001;
    doReq(32'hABCD_E123, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R2 paValid", {31'b0, paValid}, 32'd1);
    chk("R2 paPage", paPage, expPage(32'hABCD_E123));
    chk("R2 paProt", {29'b0, paProt}, 32'd7);
    chk("R2 no fault", {31'b0, faultReq}, 32'd0);
  endtask

  task automatic tAbsent();
    cfgMmuPresent = 1'b0;
    doReq(32'h1111_2345, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R3 absent paValid", {31'b0, paValid}, 32'd1);
    chk("R3 absent paPage", paPage, 32'h1111_2000);
    chk("R3 absent no fault", {31'b0, faultReq}, 32'd0);
    cfgMmuPresent = 1'b1; cfgFullVersion = 1'b1; verMmuField = 1'b0;
    doReq(32'h2222_3456, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R3 field clear bypass", paPage, 32'h2222_3000);
    chk("R3 field clear no fault", {31'b0, faultReq}, 32'd0);
    verMmuField = 1'b1;
  endtask

  task automatic tHit();
    lkVbase = 32'h1234_0000; lkPbase = 32'h8000_0000; lkProt = 3'b101;
    doReq(32'h1234_5678, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R4 paValid", {31'b0, paValid}, 32'd1);
    chk("R4 paPage", paPage, 32'h8000_0000 + expPage(32'h1234_5678) - 32'h1234_0000);
    chk("R4 paProt", {29'b0, paProt}, 32'd5);
    chk("R4 no fault", {31'b0, faultReq}, 32'd0);
  endtask

  task automatic tFaults();
    for (int k = 0; k < 3; k++) begin
      for (int p = 0; p < 2; p++) begin
        logic [31:0] va;
        va = 32'h4000_0010 + 32'(k * 16 + p);
        doReq(va, 2'(k), 1'b1, 1'b0, p[0], 1'b0);
        chk("R5 faultReq", {31'b0, faultReq}, 32'd1);
        chk("R5 no paValid", {31'b0, paValid}, 32'd0);
        chk("R5 ear", earOut, va);
        chk("R6 R7 esr", esrOut, expEsr(2'(k), p[0]));
        chk("R8 pending set", {31'b0, faultPending}, 32'd1);
        @(negedge clk);
        chk("R5 pulse ends", {31'b0, faultReq}, 32'd0);
        ackOnly();
        chk("R8 pending cleared", {31'b0, faultPending}, 32'd0);
      end
    end
  endtask

  task automatic tCollision();
    doReq(32'h5000_0004, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    doReq(32'h5000_0008, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R10 fresh pulse", {31'b0, faultReq}, 32'd1);
    chk("R10 ear updated", earOut, 32'h5000_0008);
    chk("R10 esr updated", esrOut, expEsr(2'd1, 1'b1));
    chk("R10 pending kept", {31'b0, faultPending}, 32'd1);
    chk("R10 not recursive", {31'b0, recursiveFault}, 32'd0);
    ackOnly();
  endtask

  task automatic tIdle();
    repeat (3) @(negedge clk);
    chk("R11 idle paValid", {31'b0, paValid}, 32'd0);
  endtask

  task automatic tRecursive();
    doReq(32'h6000_0100, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
    doReq(32'h6000_0200, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R9 recursive set", {31'b0, recursiveFault}, 32'd1);
    chk("R9 no pulse", {31'b0, faultReq}, 32'd0);
    chk("R9 ear kept", earOut, 32'h6000_0100);
    chk("R9 esr kept", esrOut, expEsr(2'd2, 1'b0));
    ackOnly();
    chk("R8 ack clears", {31'b0, faultPending}, 32'd0);
    chk("R9 sticky", {31'b0, recursiveFault}, 32'd1);
    applyReset();
    chk("R1 recursive reset", {31'b0, recursiveFault}, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBypass();
    tAbsent();
    tHit();
    tFaults();
    tCollision();
    tIdle();
    tRecursive();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule